// File: doc/BRIEF.md
# Bridge Fault Protection Manager

This block turns digitized fault indications from a motor H-bridge into two decisions: whether the bridge may drive, and whether a fault is being reported. Its inputs are one overcurrent comparator bit per power switch, the gate command of each switch, an undervoltage flag and an unsigned junction-temperature code in degrees Celsius. Its outputs are `bridge_dis`, which forces every switch off, and `fault_n`, an active-low fault indication meant for an open-drain pad.

An overcurrent is sampled only on a switch that is commanded on, and only after a blanking window that starts with the turn-on sample. This keeps the charging current of the motor's capacitance from being flagged. A sampled overcurrent is confirmed when it is present on two consecutive clock samples. A confirmed overcurrent locks the bridge off for a fixed protection period, after which driving is retried. The lockout is a three-state machine. In ST_ARMED a qualified hit takes the transition *suspect*. In ST_SUSPECT a second hit takes *confirm* into ST_LOCKOUT, and a missing hit takes *dismiss* back to ST_ARMED. ST_LOCKOUT counts down the period and then takes *retry* to ST_ARMED. Two temperature comparators with hysteresis produce a warning and a shutdown. The warning only reports; the shutdown also disables the bridge. The undervoltage flag disables the bridge and reports a fault for as long as it is present. The flag's own hysteresis belongs to the analog comparator that produces it.

Top module: `bridge_fault_mgr`

## Requirements
- R1: After reset, with the temperature code below both clear levels and no undervoltage, `bridge_dis` is 0 and `fault_n` is 1.
- R2: An overcurrent bit is ignored while its switch's `sw_on` bit is 0. It is also ignored in the first BLANK_CYC clock samples of a turn-on, counting from the first sample with `sw_on` high after a sample with it low.
- R3: A qualified overcurrent, on any switch, present on exactly one sample leaves `bridge_dis` at 0. Qualified overcurrents on two consecutive samples make `bridge_dis` go to 1 in the cycle after the second sample.
- R4: A confirmed overcurrent holds `bridge_dis` at 1 for exactly PROT_CYC cycles, after which the bridge is released (retry).
- R5: Overcurrent samples taken during a lockout are ignored. If the overcurrent is still qualified after the retry, `bridge_dis` stays 0 for exactly two cycles and then starts a new full PROT_CYC lockout.
- R6: The thermal warning is set in the cycle after a sample with `temp_code` >= TW_SET. It clears in the cycle after a sample with `temp_code` <= TW_SET-T_HYST, and otherwise keeps its value. It drives `fault_n` low and does not affect `bridge_dis`.
- R7: Thermal shutdown follows the same rule with TSD_SET and TSD_SET-T_HYST. It drives both `bridge_dis` to 1 and `fault_n` to 0.
- R8: In the cycle after a sample with `uv_flag` high, `bridge_dis` is 1 and `fault_n` is 0. Both release in the cycle after `uv_flag` is sampled low, unless another condition holds them.
- R9: `fault_n` is 0 in every cycle in which `bridge_dis` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_on | input | NSW | Gate command per switch, 1 = on |
| oc_cmp | input | NSW | Overcurrent comparator per switch, 1 = over limit |
| uv_flag | input | 1 | Supply undervoltage, 1 = below threshold |
| temp_code | input | TEMP_W | Junction temperature in degrees Celsius, unsigned |
| bridge_dis | output | 1 | 1 = all bridge switches forced off |
| fault_n | output | 1 | Active-low fault indication |

## Verification
On every cycle, the assertions check the following: a lockout can only begin after two consecutive qualified hits, it never outlasts PROT_CYC and it always ends at that count, a switch that is off or just turning on never produces a hit, a hot or undervoltage sample disables the bridge in the next cycle, and a disabled bridge always reports a fault. The exact width of the blanking window per switch, the exact lockout length, the two-cycle gap before a re-lock, and the hysteresis bands seen on full up and down temperature ramps are shown only by the bench scenarios, which compare against arithmetic expectations.

// File: rtl/bfm_pkg.sv
package bfm_pkg;
    typedef enum logic [1:0] {
        ST_ARMED   = 2'd0,
        ST_SUSPECT = 2'd1,
        ST_LOCKOUT = 2'd2
    } ocp_state_e;
endpackage

// File: rtl/bfm_oc_blanker.sv
module bfm_oc_blanker #(
    parameter int NSW       = 4,
    parameter int BLANK_CYC = 150
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NSW-1:0] sw_on,
    input  logic [NSW-1:0] oc_cmp,
    output logic           hit_o
);
    localparam int BW = $clog2(BLANK_CYC + 1);

    logic [NSW-1:0] qual;

    for (genvar i = 0; i < NSW; i++) begin : g_sw
        logic          sw_q;
        logic [BW-1:0] bcnt;
        logic          rise;
        logic          blanked;

        assign rise    = sw_on[i] & ~sw_q;
        assign blanked = rise | (bcnt != '0);
        assign qual[i] = sw_on[i] & oc_cmp[i] & ~blanked;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sw_q <= 1'b0;
                bcnt <= '0;
            end else begin
                sw_q <= sw_on[i];
                if (rise)
                    bcnt <= BW'(BLANK_CYC - 1);
                else if (bcnt != '0)
                    bcnt <= bcnt - 1'b1;
            end
        end

        // R2: the turn-on sample itself is always masked
        p_turnon_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sw_on[i]) |-> !qual[i]);
    end

    assign hit_o = |qual;

    // R2: a switch that is off never contributes a hit
    p_off_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((sw_on & oc_cmp) == '0) |-> !hit_o);
endmodule

// File: rtl/bfm_ocp_lockout.sv
module bfm_ocp_lockout
    import bfm_pkg::*;
#(
    parameter int PROT_CYC = 60000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    output logic lock_o
);
    localparam int PW = $clog2(PROT_CYC + 1);

    ocp_state_e    state, nxt;
    logic [PW-1:0] pcnt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_ARMED:   if (hit_i) nxt = ST_SUSPECT;
            ST_SUSPECT: nxt = hit_i ? ST_LOCKOUT : ST_ARMED;
            ST_LOCKOUT: if (pcnt == '0) nxt = ST_ARMED;
            default:    nxt = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_ARMED;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pcnt <= '0;
        else if (state != ST_LOCKOUT && nxt == ST_LOCKOUT)
            pcnt <= PW'(PROT_CYC - 1);
        else if (state == ST_LOCKOUT && pcnt != '0)
            pcnt <= pcnt - 1'b1;
    end

    always_comb lock_o = (state == ST_LOCKOUT);

    // Checker: independent run-length of the current lockout
    logic [PW-1:0] lock_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      lock_len <= '0;
        else if (lock_o) lock_len <= lock_len + 1'b1;
        else             lock_len <= '0;
    end

    // R3: lockout begins only after two consecutive hits
    p_two_hits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> ($past(hit_i) && $past(hit_i, 2)));
    // R4: lockout never outlasts the period
    p_lock_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |-> (lock_len < PW'(PROT_CYC)));
    // R4: lockout always ends once the period is used up
    p_lock_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_o && lock_len == PW'(PROT_CYC - 1)) |=> !lock_o);
endmodule

// File: rtl/bfm_temp_hyst.sv
module bfm_temp_hyst #(
    parameter int TEMP_W  = 8,
    parameter int SET_LVL = 160,
    parameter int CLR_LVL = 145
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp,
    output logic              flag_o
);
    localparam logic [TEMP_W-1:0] ON_T  = TEMP_W'(SET_LVL);
    localparam logic [TEMP_W-1:0] OFF_T = TEMP_W'(CLR_LVL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             flag_o <= 1'b0;
        else if (temp >= ON_T)  flag_o <= 1'b1;
        else if (temp <= OFF_T) flag_o <= 1'b0;
    end
endmodule

// File: rtl/bridge_fault_mgr.sv
module bridge_fault_mgr #(
    parameter int NSW       = 4,
    parameter int TEMP_W    = 8,
    parameter int TW_SET    = 160,
    parameter int TSD_SET   = 175,
    parameter int T_HYST    = 15,
    parameter int BLANK_CYC = 150,
    parameter int PROT_CYC  = 60000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSW-1:0]    sw_on,
    input  logic [NSW-1:0]    oc_cmp,
    input  logic              uv_flag,
    input  logic [TEMP_W-1:0] temp_code,
    output logic              bridge_dis,
    output logic              fault_n
);
    localparam logic [TEMP_W-1:0] TW_ON  = TEMP_W'(TW_SET);
    localparam logic [TEMP_W-1:0] TSD_ON = TEMP_W'(TSD_SET);

    logic oc_hit, oc_lock, warn, shut, uv_q;

    bfm_oc_blanker #(.NSW(NSW), .BLANK_CYC(BLANK_CYC)) u_blank (
        .clk(clk), .rst_n(rst_n), .sw_on(sw_on), .oc_cmp(oc_cmp), .hit_o(oc_hit)
    );

    bfm_ocp_lockout #(.PROT_CYC(PROT_CYC)) u_lock (
        .clk(clk), .rst_n(rst_n), .hit_i(oc_hit), .lock_o(oc_lock)
    );

    bfm_temp_hyst #(.TEMP_W(TEMP_W), .SET_LVL(TW_SET), .CLR_LVL(TW_SET - T_HYST)) u_warn (
        .clk(clk), .rst_n(rst_n), .temp(temp_code), .flag_o(warn)
    );

    bfm_temp_hyst #(.TEMP_W(TEMP_W), .SET_LVL(TSD_SET), .CLR_LVL(TSD_SET - T_HYST)) u_shut (
        .clk(clk), .rst_n(rst_n), .temp(temp_code), .flag_o(shut)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) uv_q <= 1'b0;
        else        uv_q <= uv_flag;
    end

    always_comb begin
        bridge_dis = oc_lock | shut | uv_q;
        fault_n    = ~(oc_lock | shut | warn | uv_q);
    end

    // R6: a hot sample reports a fault in the next cycle
    p_warn_reports_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_code >= TW_ON) |=> !fault_n);
    // R7: a shutdown-level sample disables the bridge in the next cycle
    p_shut_disables_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_code >= TSD_ON) |=> bridge_dis);
    // R8: undervoltage disables and reports in the next cycle
    p_uv_locks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        uv_flag |=> (bridge_dis && !fault_n));
    // R9: a disabled bridge always reports
    p_dis_reports_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bridge_dis |-> !fault_n);
endmodule

// File: tb/bridge_fault_mgr_bench.sv
module bridge_fault_mgr_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NSW   = 4;
    localparam int BLANK = 4;
    localparam int PROT  = 20;
    localparam int TWS   = 160;
    localparam int TSS   = 175;
    localparam int HYS   = 15;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NSW-1:0] sw_on = '0;
    logic [NSW-1:0] oc_cmp = '0;
    logic           uv_flag = 1'b0;
    logic [7:0]     temp_code = '0;
    logic           bridge_dis, fault_n;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bridge_fault_mgr #(
        .NSW(NSW), .TEMP_W(8), .TW_SET(TWS), .TSD_SET(TSS), .T_HYST(HYS),
        .BLANK_CYC(BLANK), .PROT_CYC(PROT)
    ) u_bridge_fault_mgr (
        .clk(clk), .rst_n(rst_n), .sw_on(sw_on), .oc_cmp(oc_cmp),
        .uv_flag(uv_flag), .temp_code(temp_code),
        .bridge_dis(bridge_dis), .fault_n(fault_n)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic steps(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic lock_len(output int n);
        n = 0;
        while (bridge_dis && n < 1000) begin
            n++;
            step();
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        bit ew, es;
        steps(2);
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk(bridge_dis == 1'b0, "R1 dis", int'(bridge_dis), 0);
        chk(fault_n == 1'b1, "R1 fault_n", int'(fault_n), 1);

        // R2/R3 blanking sweep: overcurrent on offsets d and d+1 after turn-on
        for (int s = 0; s < NSW; s++) begin
            for (int d = 0; d < 8; d++) begin
                sw_on[s] = 1'b1;
                steps(d);
                oc_cmp[s] = 1'b1;
                steps(2);
                oc_cmp = '0;
                chk(bridge_dis == (d >= BLANK), "R2 blank window",
                    int'(bridge_dis), int'(d >= BLANK));
                sw_on = '0;
                steps(PROT + 3);
            end
        end

        // R2: overcurrent on a switch that is off is ignored
        sw_on = 4'b0001;
        steps(BLANK + 2);
        oc_cmp = 4'b0010;
        steps(4);
        chk(bridge_dis == 1'b0, "R2 off switch", int'(bridge_dis), 0);
        oc_cmp = '0;

        // R3: single qualified sample is dismissed
        oc_cmp = 4'b0001;
        step();
        oc_cmp = '0;
        steps(2);
        chk(bridge_dis == 1'b0, "R3 single sample", int'(bridge_dis), 0);
        chk(fault_n == 1'b1, "R3 single sample fault_n", int'(fault_n), 1);

        // R3/R4: confirmed lock, exact length, fault_n reported (R9)
        oc_cmp = 4'b0001;
        step();
        chk(bridge_dis == 1'b0, "R3 after first hit", int'(bridge_dis), 0);
        step();
        oc_cmp = '0;
        chk(bridge_dis == 1'b1, "R3 confirm", int'(bridge_dis), 1);
        chk(fault_n == 1'b0, "R9 fault during lock", int'(fault_n), 0);
        lock_len(n);
        chk(n == PROT, "R4 lock length", n, PROT);
        chk(fault_n == 1'b1, "R4 released fault_n", int'(fault_n), 1);

        // R5: persistent overcurrent, retry re-locks after two cycles
        oc_cmp = 4'b0001;
        steps(2);
        chk(bridge_dis == 1'b1, "R5 first lock", int'(bridge_dis), 1);
        lock_len(n);
        chk(n == PROT, "R5 first length", n, PROT);
        chk(bridge_dis == 1'b0, "R5 retry gap 1", int'(bridge_dis), 0);
        step();
        chk(bridge_dis == 1'b0, "R5 retry gap 2", int'(bridge_dis), 0);
        step();
        chk(bridge_dis == 1'b1, "R5 relock", int'(bridge_dis), 1);
        lock_len(n);
        chk(n == PROT, "R5 second length", n, PROT);
        oc_cmp = '0;
        sw_on = '0;
        steps(4);

        // R8 undervoltage
        uv_flag = 1'b1;
        step();
        chk(bridge_dis == 1'b1, "R8 uv dis", int'(bridge_dis), 1);
        chk(fault_n == 1'b0, "R8 uv fault_n", int'(fault_n), 0);
        steps(3);
        chk(bridge_dis == 1'b1, "R8 uv held", int'(bridge_dis), 1);
        uv_flag = 1'b0;
        step();
        chk(bridge_dis == 1'b0, "R8 uv release", int'(bridge_dis), 0);
        chk(fault_n == 1'b1, "R8 uv release fault_n", int'(fault_n), 1);

        // R6/R7 thermal ramps up then down, hysteresis modelled arithmetically
        ew = 1'b0;
        es = 1'b0;
        for (int p = 0; p < 512; p++) begin
            int t;
            t = (p < 256) ? p : 511 - p;
            temp_code = 8'(t);
            step();
            if (t >= TWS) ew = 1'b1; else if (t <= TWS - HYS) ew = 1'b0;
            if (t >= TSS) es = 1'b1; else if (t <= TSS - HYS) es = 1'b0;
            chk(bridge_dis == es, "R7 shutdown hysteresis", int'(bridge_dis), int'(es));
            chk(fault_n == !(ew | es), "R6 warning hysteresis", int'(fault_n), int'(!(ew | es)));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule